// File: doc/BRIEF.md
# Supervisory Power-On Reset Generator

This block turns a sampled supply-level code into a system reset. Each clock cycle the unsigned supply code is compared against a trip threshold held in a writable register. A supply code that is equal to or below the threshold forces reset on the next clock edge and clears the hold-off timing. Reset is released only after the supply has stayed above the threshold for a full hold-off window. Any dip during that window starts the window again from zero.

The hold-off window is the product of two parameters. The first is a prescaler division, which is the number of clocks per timebase tick. The second is a tick count, which is the number of ticks in the hold-off. With a 50 MHz clock, the defaults give 200 ms. Simulation overrides both with small values. The pin is open-drain and is modelled as a pull-down enable plus the resolved pin level. A parameter selects the active-low or active-high variant. The module's own reset puts it in the reset-asserted state with all timing counters cleared.

Top module: `por_supervisor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, reset is asserted and the trip register holds `TRIP_INIT`.
- R2: Reset is released exactly at the clock edge that completes DIV*HOLD consecutive edges at which the supply code was above the trip code.
- R3: A supply code sampled below the trip code asserts reset at that same clock edge, whatever state the block was in before.
- R4: A supply code equal to the trip code counts as below the threshold and asserts reset.
- R5: A single below-threshold sample during the hold-off window restarts the full DIV*HOLD window.
- R6: When `trip_wr` is high at an edge, `trip_code` is loaded into the trip register. The new value governs comparisons from the following edge onward; the edge of the write itself still uses the old value.
- R7: With ACTIVE_LOW=1, `rst_pull` is 1 exactly while reset is asserted, and `rst_pin` is 0 while reset is asserted and 1 otherwise.
- R8: With ACTIVE_LOW=0, `rst_pull` is 1 exactly while reset is released, and `rst_pin` is 1 while reset is asserted and 0 otherwise.
- R9: Codes compare as unsigned numbers: a supply code of 8'h80 is above a trip code of 8'h7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low module reset |
| supply_code | input | CODE_W | Sampled supply level, unsigned |
| trip_wr | input | 1 | Load strobe for the trip register |
| trip_code | input | CODE_W | New trip threshold, loaded when `trip_wr` is high |
| rst_pull | output | 1 | Open-drain pull-down enable |
| rst_pin | output | 1 | Resolved level of the reset pin |

## Verification
The bench places a sample that exactly equals the threshold. A design using a strict less-than comparison would keep counting toward release. It also places a one-cycle dip in the middle of the hold-off window, which a design that only pauses its counter would reveal by releasing early. The release edge is checked on the exact cycle, so an off-by-one in either the prescaler or the tick counter shows up as a late or early release. A threshold write is checked on the edge where it occurs, and the comparison is checked across the sign bit. Both polarity variants run side by side, so a swapped drive enable is also caught.

// File: rtl/por_pkg.sv
package por_pkg;

  // Supply at or below the threshold counts as a low-supply sample.
  function automatic logic supply_low(input logic [15:0] supply, input logic [15:0] trip);
    return supply <= trip;
  endfunction

  // True when the tick about to be counted is the last one of the hold-off.
  function automatic logic holdoff_last(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

  // Pin level seen on an open-drain line with pull-up, given the asserted state.
  function automatic logic pin_level(input logic asserted, input logic active_low);
    return active_low ? ~asserted : asserted;
  endfunction

endpackage

// File: rtl/por_trip_reg.sv
module por_trip_reg #(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] TRIP_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] trip
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  trip <= TRIP_INIT;
    else if (wr) trip <= wdata;
  end
endmodule

// File: rtl/por_prescaler.sv
module por_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pcnt;
      assign tick = run && (pcnt == PW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt <= '0;
        else if (clear)  pcnt <= '0;
        else if (run)    pcnt <= tick ? '0 : pcnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/por_holdoff.sv
module por_holdoff
  import por_pkg::*;
#(
  parameter int HOLD = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low,
  input  logic tick,
  output logic asserted
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asserted <= 1'b1;
      cnt      <= '0;
    end else if (low) begin
      asserted <= 1'b1;
      cnt      <= '0;
    end else if (asserted && tick) begin
      if (holdoff_last(int'(cnt), HOLD)) begin
        asserted <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/por_supervisor.sv
module por_supervisor
  import por_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int DIV = 50000,
  parameter int HOLD = 200,
  parameter bit ACTIVE_LOW = 1'b1,
  parameter logic [CODE_W-1:0] TRIP_INIT = CODE_W'(2 ** (CODE_W - 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] supply_code,
  input  logic              trip_wr,
  input  logic [CODE_W-1:0] trip_code,
  output logic              rst_pull,
  output logic              rst_pin
);
  logic [CODE_W-1:0] trip_q;
  logic              below_w;
  logic              tick_w;
  logic              asserted_q;

  por_trip_reg #(.CODE_W(CODE_W), .TRIP_INIT(TRIP_INIT)) u_trip (
    .clk(clk), .rst_n(rst_n), .wr(trip_wr), .wdata(trip_code), .trip(trip_q)
  );

  assign below_w = supply_low(16'(supply_code), 16'(trip_q));

  por_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .clear(below_w), .run(asserted_q), .tick(tick_w)
  );

  por_holdoff #(.HOLD(HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .low(below_w), .tick(tick_w), .asserted(asserted_q)
  );

  assign rst_pin  = pin_level(asserted_q, ACTIVE_LOW);
  assign rst_pull = ~rst_pin;
endmodule

// File: rtl/por_supervisor_chk.sv
module por_supervisor_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              below_w,
  input logic              tick_w,
  input logic              asserted_q,
  input logic              trip_wr,
  input logic [CODE_W-1:0] trip_code,
  input logic [CODE_W-1:0] trip_q,
  input logic              rst_pull,
  input logic              rst_pin
);
  a_r1_reset_exit_asserted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> asserted_q);

  a_r3_low_sample_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    below_w |=> asserted_q);

  a_r2_release_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asserted_q) |-> $past(tick_w) && !$past(below_w));

  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (asserted_q && !tick_w) |=> asserted_q);

  a_r6_trip_loads: assert property (@(posedge clk) disable iff (!rst_n)
    trip_wr |=> trip_q == $past(trip_code));

  a_r7_open_drain_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pull == !rst_pin);
endmodule

bind por_supervisor por_supervisor_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .below_w(below_w), .tick_w(tick_w),
  .asserted_q(asserted_q), .trip_wr(trip_wr), .trip_code(trip_code),
  .trip_q(trip_q), .rst_pull(rst_pull), .rst_pin(rst_pin)
);

// File: tb/por_supervisor_tb.sv
module por_supervisor_tb;
  localparam int DIV = 3;
  localparam int HOLD = 5;
  localparam int WIN = DIV * HOLD;

  typedef struct {
    string req;
    bit    asserted;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] supply = 8'h00;
  logic       twr = 1'b0;
  logic [7:0] tcode = 8'h00;
  logic       al_pull, al_pin, ah_pull, ah_pin;

  int total = 0;
  int bad = 0;
  exp_t q[$];

  bit         m_asserted;
  int         m_run;
  logic [7:0] m_trip;

  always #10 clk = ~clk;

  por_supervisor #(.CODE_W(8), .DIV(DIV), .HOLD(HOLD), .ACTIVE_LOW(1'b1), .TRIP_INIT(8'h40)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_code(supply), .trip_wr(twr), .trip_code(tcode),
    .rst_pull(al_pull), .rst_pin(al_pin)
  );

  por_supervisor #(.CODE_W(8), .DIV(DIV), .HOLD(HOLD), .ACTIVE_LOW(1'b0), .TRIP_INIT(8'h40)) u_dut_hi (
    .clk(clk), .rst_n(rst_n), .supply_code(supply), .trip_wr(twr), .trip_code(tcode),
    .rst_pull(ah_pull), .rst_pin(ah_pin)
  );

  task automatic check(string req, bit act, bit exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string req, bit exp_asserted);
    check({req, "/R7"}, al_pull, exp_asserted, "low-variant pull");
    check({req, "/R7"}, al_pin, !exp_asserted, "low-variant pin");
    check({req, "/R8"}, ah_pull, !exp_asserted, "high-variant pull");
    check({req, "/R8"}, ah_pin, exp_asserted, "high-variant pin");
  endtask

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic step(string req, logic [7:0] s, bit wr = 1'b0, logic [7:0] t = 8'h00);
    exp_t e;
    @(negedge clk);
    supply = s; twr = wr; tcode = t;
    if (s <= m_trip) begin
      m_asserted = 1'b1;
      m_run = 0;
    end else if (m_asserted) begin
      m_run++;
      if (m_run == WIN) begin
        m_asserted = 1'b0;
        m_run = 0;
      end
    end
    if (wr) m_trip = t;
    e.req = req;
    e.asserted = m_asserted;
    q.push_back(e);
  endtask

  // Monitor: compare after each edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check_all(e.req, e.asserted);
    end
  end

  initial begin
    m_asserted = 1'b1;
    m_run = 0;
    m_trip = 8'h40;
    repeat (3) @(negedge clk);
    check_all("R1", 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check_all("R1", 1'b1);

    // R3: below-threshold supply holds reset.
    for (int i = 0; i < 3; i++) step("R3", 8'h30);
    // R2: exact release after WIN above samples.
    for (int i = 0; i < WIN + 3; i++) step("R2", 8'h41);
    // R4: equality asserts.
    step("R4", 8'h40);
    for (int i = 0; i < 8; i++) step("R2", 8'hA0);
    // R5: dip mid-window restarts the count.
    step("R5", 8'h10);
    for (int i = 0; i < WIN + 2; i++) step("R5", 8'hA0);
    // R6: raise threshold; write edge still uses old value.
    step("R6", 8'h90, 1'b1, 8'hC0);
    step("R6", 8'h90);
    for (int i = 0; i < WIN + 1; i++) step("R6", 8'hC1);
    // R9: unsigned comparison across the top bit.
    step("R9", 8'h7F, 1'b1, 8'h7F);
    for (int i = 0; i < WIN + 2; i++) step("R9", 8'h80);
    // R3: drop from released state.
    step("R3", 8'h00);
    step("R3", 8'hFF);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule